// File: doc/BRIEF.md
# Parallel NOR Flash Bus Front End

This block is the host-facing side of a parallel NOR-style flash model. A host drives active-low chip enable, output enable and write enable strobes, an address bus and a 16-bit bidirectional data bus. There is no clock relationship between the host and the block. The block samples every strobe through a two-flop synchronizer on its own system clock. It acts on a write when it sees the synchronized write enable rise while chip enable is low.

Commands are taken from the low byte of the data bus. The supported commands are read array, read status and program setup. A program takes two write cycles. The first cycle carries the setup command. The second cycle carries the target address and the data word, and both are taken as they stand when write enable rises. The block holds that address and data internally for a fixed busy interval, then commits the word to a small internal register file that stands in for the array.

During reads the block drives either array data or a status word, depending on its current read mode. It releases the bus whenever it is deselected, its outputs are disabled, or it is held in reset. A system reset and an active-low device reset both clear the write state machine and return the block to array reads.

Top module: `nor_bus_front`

## Requirements
- R1: A write is taken only when the synchronized write enable rises while chip enable is low. A write with chip enable high has no effect. Data bits 15:8 are ignored when a command is decoded.
- R2: A program is the setup code 0x40 on one write, followed by a second write. The word of the second write is stored at the address of the second write, and array reads return it afterwards.
- R3: The address and data of the second program write are the values present at the rising edge of write enable. Earlier values during the same pulse are discarded.
- R4: The data bus is driven only when chip enable and output enable are both low. In every other case it is high impedance.
- R5: While the device reset input is low, the bus is high impedance even with chip enable and output enable low. A pending program setup is abandoned, so the next write is decoded as a command.
- R6: When the device reset is released, the block is in read-array mode.
- R7: Code 0xFF selects read-array mode and code 0x70 selects read-status mode. Any other code written outside a program sequence leaves the mode unchanged.
- R8: The status word has bit 7 as a ready flag, and all other bits are 0. Ready is 0 for BUSY_CYC clock cycles after the second program write is accepted, and 1 otherwise.
- R9: After a program is accepted, reads return the status word until a 0xFF command is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| dev_rst_n | input | 1 | Asynchronous active-low device reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | AW | Word address |
| dq | inout | DW | Bidirectional data bus |

## Verification
Writes are made in several forms: with chip enable high, with a non-zero upper byte, and with unknown codes. These separate a correct write qualification and byte selection from a decoder that looks at the wrong bits or ignores chip enable. The second program write changes both address and data in the middle of the pulse, so a design that latches on the falling edge stores the wrong word at the wrong location. Reads use every combination of chip enable and output enable, plus a held device reset. This separates a correct bus release from one that checks only one of the two strobes. Status is polled both inside and after the busy window, and array reads follow a 0xFF command, which together confirm the ready timing and the sticky status mode.

// File: rtl/nbf_pkg.sv
package nbf_pkg;
  localparam logic [7:0] CMD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_STATUS = 8'h70;
  localparam logic [7:0] CMD_SETUP  = 8'h40;

  typedef enum logic [1:0] {
    MD_ARRAY  = 2'd0,
    MD_STATUS = 2'd1,
    MD_SETUP  = 2'd2
  } rd_mode_t;
endpackage

// File: rtl/nbf_sync.sv
module nbf_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/nbf_cmd_ctl.sv
module nbf_cmd_ctl import nbf_pkg::*; #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int BUSY_CYC = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output rd_mode_t      mode,
  output logic          busy,
  output logic          commit,
  output logic [AW-1:0] hold_addr,
  output logic [DW-1:0] hold_data
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(BUSY_CYC - 1);

  logic [CW-1:0] cnt;
  logic [7:0]    code;

  assign code = wr_data[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= MD_ARRAY;
      busy      <= 1'b0;
      commit    <= 1'b0;
      cnt       <= '0;
      hold_addr <= '0;
      hold_data <= '0;
    end else begin
      commit <= 1'b0;
      if (busy) begin
        if (cnt == '0) begin
          busy   <= 1'b0;
          commit <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (strobe) begin
        if (mode == MD_SETUP) begin
          hold_addr <= wr_addr;
          hold_data <= wr_data;
          busy      <= 1'b1;
          cnt       <= CNT_LOAD;
          mode      <= MD_STATUS;
        end else begin
          unique case (code)
            CMD_ARRAY:  mode <= MD_ARRAY;
            CMD_STATUS: mode <= MD_STATUS;
            CMD_SETUP:  if (!busy) mode <= MD_SETUP;
            default:    mode <= mode;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/nbf_array.sv
module nbf_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/nor_bus_front.sv
module nor_bus_front import nbf_pkg::*; #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int BUSY_CYC = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dev_rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  inout  wire  [DW-1:0] dq
);
  localparam int SW = 4;

  logic [SW-1:0] pins_s;
  logic rst_n_s, ce_s, oe_s, we_s, we_d;
  logic int_rst, wr_strobe;
  rd_mode_t mode;
  logic busy, commit;
  logic [AW-1:0] hold_addr;
  logic [DW-1:0] hold_data, arr_q, status_w, dq_q;
  logic dq_oe_q;

  nbf_sync #(.W(SW), .RST_VAL('1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({dev_rst_n, ce_n, oe_n, we_n}),
    .q   (pins_s)
  );

  assign {rst_n_s, ce_s, oe_s, we_s} = pins_s;
  assign int_rst = rst | ~rst_n_s;

  always_ff @(posedge clk) begin
    if (int_rst) we_d <= 1'b1;
    else         we_d <= we_s;
  end

  assign wr_strobe = we_s & ~we_d & ~ce_s;

  nbf_cmd_ctl #(.AW(AW), .DW(DW), .BUSY_CYC(BUSY_CYC)) u_ctl (
    .clk       (clk),
    .rst       (int_rst),
    .strobe    (wr_strobe),
    .wr_addr   (addr),
    .wr_data   (dq),
    .mode      (mode),
    .busy      (busy),
    .commit    (commit),
    .hold_addr (hold_addr),
    .hold_data (hold_data)
  );

  nbf_array #(.AW(AW), .DW(DW)) u_arr (
    .clk     (clk),
    .wr_en   (commit),
    .wr_addr (hold_addr),
    .wr_data (hold_data),
    .rd_addr (addr),
    .rd_data (arr_q)
  );

  assign status_w = {{(DW-8){1'b0}}, ~busy, 7'b0};

  always_ff @(posedge clk) begin
    if (int_rst) begin
      dq_oe_q <= 1'b0;
      dq_q    <= '0;
    end else begin
      dq_oe_q <= ~ce_s & ~oe_s;
      dq_q    <= (mode == MD_ARRAY) ? arr_q : status_w;
    end
  end

  assign dq = dq_oe_q ? dq_q : {DW{1'bz}};
endmodule

// File: rtl/nbf_checker.sv
module nbf_checker import nbf_pkg::*; (
  input logic     clk,
  input logic     rst,
  input logic     rst_n_s,
  input logic     ce_s,
  input logic     oe_s,
  input logic     dq_oe_q,
  input logic     wr_strobe,
  input logic     busy,
  input rd_mode_t mode
);
  AST_DRIVE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
    dq_oe_q |-> $past(!ce_s && !oe_s && rst_n_s)); // R4

  AST_RESET_RELEASES_BUS: assert property (@(posedge clk) disable iff (rst)
    !rst_n_s |=> !dq_oe_q); // R5

  AST_RESET_ARRAY_MODE: assert property (@(posedge clk) disable iff (rst)
    !rst_n_s |=> mode == MD_ARRAY); // R6

  AST_MODE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (mode != $past(mode)) |-> ($past(wr_strobe) || !$past(rst_n_s))); // R1

  AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_strobe)); // R8

  AST_PROG_GIVES_STATUS: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> mode == MD_STATUS); // R9
endmodule

bind nor_bus_front nbf_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .rst_n_s   (rst_n_s),
  .ce_s      (ce_s),
  .oe_s      (oe_s),
  .dq_oe_q   (dq_oe_q),
  .wr_strobe (wr_strobe),
  .busy      (busy),
  .mode      (mode)
);

// File: tb/sim_nor_bus_front.sv
`timescale 1ns/1ps
module sim_nor_bus_front;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int BUSY_CYC = 32;
  localparam logic [DW-1:0] HIZ = 16'hFFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dev_rst_n = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic tb_drv = 1'b0;
  logic [DW-1:0] tb_dq = '0;
  wire  [DW-1:0] dq;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  assign dq = tb_drv ? tb_dq : {DW{1'bz}};
  for (genvar g = 0; g < DW; g++) begin : g_pu
    pullup (dq[g]);
  end

  nor_bus_front #(.AW(AW), .DW(DW), .BUSY_CYC(BUSY_CYC)) u0 (
    .clk(clk), .rst(rst), .dev_rst_n(dev_rst_n), .ce_n(ce_n),
    .oe_n(oe_n), .we_n(we_n), .addr(addr), .dq(dq)
  );

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic use_ce);
    addr = a; tb_dq = d; tb_drv = 1'b1; ce_n = ~use_ce;
    cyc(2); we_n = 1'b0; cyc(4); we_n = 1'b1; cyc(4);
    tb_drv = 1'b0; ce_n = 1'b1; cyc(2);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; cyc(6);
    d = dq; oe_n = 1'b1; ce_n = 1'b1; cyc(4);
  endtask

  task automatic t_program;
    logic [DW-1:0] v;
    bus_write(6'd7, 16'h0040, 1'b1);
    addr = 6'd9; tb_dq = 16'hBEEF; tb_drv = 1'b1; ce_n = 1'b0;
    cyc(2); we_n = 1'b0; cyc(3);
    addr = 6'd7; tb_dq = 16'hCAFE; cyc(3);
    we_n = 1'b1; cyc(4); tb_drv = 1'b0; ce_n = 1'b1; cyc(2);
    bus_read(6'd7, v); chk("R8 busy status", v, 16'h0000);
    cyc(BUSY_CYC + 10);
    bus_read(6'd7, v); chk("R8 ready status", v, 16'h0080);
    bus_read(6'd9, v); chk("R9 status persists", v, 16'h0080);
    bus_write(6'd0, 16'h00FF, 1'b1);
    bus_read(6'd7, v); chk("R3 word at rise address", v, 16'hCAFE);
    bus_write(6'd12, 16'h0040, 1'b1);
    bus_write(6'd12, 16'h5A3C, 1'b1);
    cyc(BUSY_CYC + 10);
    bus_write(6'd0, 16'h00FF, 1'b1);
    bus_read(6'd12, v); chk("R2 programmed word", v, 16'h5A3C);
  endtask

  task automatic t_commands;
    logic [DW-1:0] v;
    bus_write(6'd0, 16'h0070, 1'b0);
    bus_read(6'd12, v); chk("R1 write with ce high ignored", v, 16'h5A3C);
    bus_write(6'd0, 16'hAB70, 1'b1);
    bus_read(6'd12, v); chk("R1 upper byte ignored", v, 16'h0080);
    bus_write(6'd0, 16'h0055, 1'b1);
    bus_read(6'd12, v); chk("R7 unknown code keeps status", v, 16'h0080);
    bus_write(6'd0, 16'h00FF, 1'b1);
    bus_read(6'd12, v); chk("R7 read array code", v, 16'h5A3C);
    bus_write(6'd0, 16'h0012, 1'b1);
    bus_read(6'd12, v); chk("R7 unknown code keeps array", v, 16'h5A3C);
  endtask

  task automatic t_bus;
    addr = 6'd12; ce_n = 1'b0; oe_n = 1'b1; cyc(6);
    chk("R4 oe high releases bus", dq, HIZ);
    ce_n = 1'b1; oe_n = 1'b0; cyc(6);
    chk("R4 ce high releases bus", dq, HIZ);
    ce_n = 1'b0; cyc(6);
    chk("R4 both low drives bus", dq, 16'h5A3C);
    ce_n = 1'b1; oe_n = 1'b1; cyc(6);
    chk("R4 deselected releases bus", dq, HIZ);
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    bus_write(6'd0, 16'h0070, 1'b1);
    addr = 6'd12; ce_n = 1'b0; oe_n = 1'b0; dev_rst_n = 1'b0; cyc(6);
    chk("R5 bus released in reset", dq, HIZ);
    ce_n = 1'b1; oe_n = 1'b1; dev_rst_n = 1'b1; cyc(4);
    bus_read(6'd12, v); chk("R6 array mode after reset", v, 16'h5A3C);
    bus_write(6'd12, 16'h0040, 1'b1);
    dev_rst_n = 1'b0; cyc(5); dev_rst_n = 1'b1; cyc(4);
    bus_write(6'd12, 16'h1299, 1'b1);
    cyc(BUSY_CYC + 10);
    bus_read(6'd12, v); chk("R5 setup abandoned by reset", v, 16'h5A3C);
  endtask

  initial begin : watchdog
    #2ms;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cyc(4); rst = 1'b0; cyc(4);
    chk("R4 bus released after reset", dq, HIZ);
    t_program();
    t_commands();
    t_bus();
    t_reset();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule